// File: doc/BRIEF.md
# Receive Ring Buffer Manager

This block places incoming frames into a circular region of an 8 KB byte-wide packet memory. A frame arrives as a stream of bytes, one per cycle, with a marker on its final byte and a good/bad indication. The block reserves six bytes at the current write position and writes the payload right after them. Once the final byte is in, it writes a small header into the reserved slot. The header holds the address where the following frame will begin, the payload byte count and a status word.

Software consumes frames by walking the chain of headers. After each frame it hands space back by writing the host read pointer. The value to write is the next-frame address minus one, or the ring end address when that value would fall below the ring start. The block never writes a byte at the read pointer. A frame that cannot fit completely is discarded and raises a sticky error flag. A counter holds the number of stored frames that software has not yet released. Software releases a frame with a one-cycle decrement strobe. A pending flag is high whenever this counter is nonzero.

A hold input parks the receive logic and disarms it. Reception starts again only after a separate arm strobe.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset the ring spans 0x0000..0x17FF, the read pointer is 0x17FF and the write position is 0x0000. The counter, pending flag, error flag and memory write strobe are all low, and reception is disarmed.
- R2: A stored frame of N bytes puts its payload at consecutive ring positions starting six bytes past the header address. The header is written last, little-endian at header+0..5: next-frame address (bytes 0-1), N (bytes 2-3), status (bytes 4-5).
- R3: Status bit 7 is 1 when the frame ended with rx_good high and 0 otherwise. All other status bits are 0.
- R4: The next-frame address is the header address plus 6 plus N, rounded up to an even value and wrapped into the ring. The following frame's header is placed there.
- R5: The counter rises by one on the edge that writes the last header byte, which is the sixth edge after the edge that takes the final byte. A decrement strobe lowers it by one when it is nonzero and is ignored at zero. pkt_pend is high exactly when the counter is nonzero.
- R6: Ring positions advance from the ring end address to the ring start address.
- R7: A frame needs 6+N+(N mod 2) bytes. If that exceeds the free bytes from the header address up to, but not including, the read pointer, the frame is discarded. No header is written, the write position and counter do not change, rx_err is set, and no byte is ever written at the read pointer.
- R8: The counter saturates at 2^CW-1 (255 by default). A frame ending while it is full is discarded with rx_err set.
- R9: A frame of exactly MAX_LEN bytes is stored. A longer frame is discarded with rx_err set.
- R10: While ring_hold is high the block writes nothing and disarms itself. After it falls, frames are ignored until rx_arm is pulsed.
- R11: A frame that starts while disarmed is ignored entirely: no memory writes, no error and no counter change.
- R12: rx_err stays set until an err_clr strobe.
- R13: Writing the ring start (cfg_sel 0) also moves the write position there. cfg_sel 1 writes the ring end and cfg_sel 2 writes the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A frame byte is present this cycle |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_good | input | 1 | Frame received correctly (sampled with rx_last) |
| cfg_we | input | 1 | Host configuration write |
| cfg_sel | input | 2 | 0 ring start, 1 ring end, 2 read pointer |
| cfg_wdata | input | AW | Configuration value |
| ring_hold | input | 1 | Hold the receive logic idle and disarm it |
| rx_arm | input | 1 | Arm reception strobe |
| pkt_dec | input | 1 | Release-one-frame strobe |
| err_clr | input | 1 | Clear the error flag |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | AW | Packet memory write address |
| mem_wdata | output | 8 | Packet memory write data |
| pkt_cnt | output | CW | Stored frames not yet released |
| pkt_pend | output | 1 | Frames pending |
| rx_err | output | 1 | Sticky receive error flag |

## Verification
The bench builds the block with MAX_LEN=64 and CW=3, so the length limit is reached with short frames and the counter saturates at 7 after a handful of frames. The address width and the default ring bounds stay at their default values, so the first frames check the reset layout. Part-way through, the bench programs a 128-byte ring at 0x100..0x17F. A few 30-byte frames then fill this ring enough to force an overtake discard and a frame that straddles the wrap point.

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr #(
  parameter int AW = 13,
  parameter logic [AW-1:0] RING_START = 13'h0000,
  parameter logic [AW-1:0] RING_END = 13'h17FF,
  parameter int MAX_LEN = 1518,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_good,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          ring_hold,
  input  logic          rx_arm,
  input  logic          pkt_dec,
  input  logic          err_clr,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic [CW-1:0] pkt_cnt,
  output logic          pkt_pend,
  output logic          rx_err
);
  localparam int PW = AW + 1;
  localparam logic [CW-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_SKIP, S_HDR} st_t;

  st_t st;
  logic [AW-1:0] ring_lo, ring_hi, rd_ptr, wr_ptr, hdr, nxt;
  logic [15:0] len;
  logic [2:0] idx;
  logic good_q, drop, armed;

  function automatic logic [AW-1:0] wrap_add(logic [AW-1:0] b, logic [PW-1:0] o,
                                            logic [AW-1:0] hi, logic [PW-1:0] n);
    logic [PW-1:0] s;
    s = {1'b0, b} + o;
    if (s > {1'b0, hi}) s = s - n;
    return s[AW-1:0];
  endfunction

  logic [PW-1:0] span, free_b;
  logic [AW-1:0] cur_hdr;
  logic [15:0] cur_len, n_len;
  logic [16:0] need;
  logic room, bad_now, keep, cnt_inc, dec_ok;
  logic [7:0] hdr_byte;

  assign span    = {1'b0, ring_hi} - {1'b0, ring_lo} + PW'(1);
  assign cur_hdr = (st == S_IDLE) ? wr_ptr : hdr;
  assign cur_len = (st == S_IDLE) ? 16'd0 : len;
  assign free_b  = (rd_ptr >= cur_hdr) ? PW'(rd_ptr - cur_hdr)
                                       : {1'b0, rd_ptr} + span - {1'b0, cur_hdr};
  assign room    = (cur_len < 16'(MAX_LEN)) && ({1'b0, cur_len} + 17'd7 <= 17'(free_b));
  assign bad_now = ((st != S_IDLE) && drop) || !room;
  assign n_len   = cur_len + 16'd1;
  assign need    = {1'b0, n_len} + 17'd6 + 17'(n_len[0]);
  assign keep    = !bad_now && (need <= 17'(free_b)) && (pkt_cnt != CNT_MAX);
  assign cnt_inc = (st == S_HDR) && (idx == 3'd5) && !ring_hold;
  assign dec_ok  = pkt_dec && (pkt_cnt != '0);
  assign pkt_pend = (pkt_cnt != '0);

  always_comb begin
    case (idx)
      3'd0: hdr_byte = 8'(16'(nxt));
      3'd1: hdr_byte = 8'(16'(nxt) >> 8);
      3'd2: hdr_byte = len[7:0];
      3'd3: hdr_byte = len[15:8];
      3'd4: hdr_byte = {good_q, 7'd0};
      default: hdr_byte = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ring_lo <= RING_START; ring_hi <= RING_END;
      rd_ptr <= RING_END; wr_ptr <= RING_START; hdr <= '0; nxt <= '0;
      len <= '0; idx <= '0; good_q <= 1'b0; drop <= 1'b0; armed <= 1'b0;
      mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0; pkt_cnt <= '0; rx_err <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      pkt_cnt <= pkt_cnt + CW'(cnt_inc) - CW'(dec_ok);
      if (err_clr) rx_err <= 1'b0;
      if (rx_arm) armed <= 1'b1;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: begin ring_lo <= cfg_wdata; wr_ptr <= cfg_wdata; end
          2'd1: ring_hi <= cfg_wdata;
          2'd2: rd_ptr <= cfg_wdata;
          default: ;
        endcase
      end
      if (ring_hold) begin
        st <= S_IDLE;
        armed <= 1'b0;
      end else begin
        case (st)
          S_IDLE, S_DATA: begin
            if (rx_valid && (st == S_DATA || armed)) begin
              hdr <= cur_hdr;
              len <= n_len;
              drop <= bad_now;
              mem_we <= !bad_now;
              mem_addr <= wrap_add(cur_hdr, PW'(cur_len) + PW'(6), ring_hi, span);
              mem_wdata <= rx_data;
              if (!rx_last) st <= S_DATA;
              else if (keep) begin
                st <= S_HDR; idx <= 3'd0; good_q <= rx_good;
                nxt <= wrap_add(cur_hdr, PW'(need), ring_hi, span);
              end else begin
                st <= S_IDLE; rx_err <= 1'b1;
              end
            end else if (rx_valid && !rx_last) st <= S_SKIP;
          end
          S_SKIP: if (rx_valid && rx_last) st <= S_IDLE;
          S_HDR: begin
            mem_we <= 1'b1;
            mem_addr <= wrap_add(hdr, PW'(idx), ring_hi, span);
            mem_wdata <= hdr_byte;
            idx <= idx + 3'd1;
            if (idx == 3'd5) begin
              wr_ptr <= nxt;
              st <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module rx_ring_chk #(
  parameter int AW = 13,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [CW-1:0] pkt_cnt,
  input logic          pkt_pend,
  input logic          ring_hold,
  input logic [AW-1:0] ring_lo,
  input logic [AW-1:0] ring_hi,
  input logic [AW-1:0] rd_ptr
);
  AST_WR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= ring_lo && mem_addr <= ring_hi)); // R6
  AST_NO_RDPTR_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr != rd_ptr)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_cnt == $past(pkt_cnt)) || (pkt_cnt == $past(pkt_cnt) + CW'(1))
    || (pkt_cnt == $past(pkt_cnt) - CW'(1))); // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_cnt == '1) |=> (pkt_cnt != '0)); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_cnt == '0) |=> (pkt_cnt != '1)); // R5
  AST_PEND_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_pend) |-> (pkt_cnt == CW'(1))); // R5
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ring_hold |=> !mem_we); // R10
endmodule

bind rx_ring_mgr rx_ring_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
  .pkt_cnt(pkt_cnt), .pkt_pend(pkt_pend), .ring_hold(ring_hold),
  .ring_lo(ring_lo), .ring_hi(ring_hi), .rd_ptr(rd_ptr)
);

// File: tb/sim_rx_ring_mgr.sv
module sim_rx_ring_mgr;
  localparam int AW = 13, MAXL = 64, CW = 3, CMAX = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, rx_valid = 1'b0, rx_last = 1'b0, rx_good = 1'b0;
  logic [7:0] rx_data = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic ring_hold = 1'b0, rx_arm = 1'b0, pkt_dec = 1'b0, err_clr = 1'b0;
  logic mem_we, pkt_pend, rx_err;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [CW-1:0] pkt_cnt;

  rx_ring_mgr #(.AW(AW), .MAX_LEN(MAXL), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_good(rx_good), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ring_hold(ring_hold), .rx_arm(rx_arm),
    .pkt_dec(pkt_dec), .err_clr(err_clr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .pkt_cnt(pkt_cnt), .pkt_pend(pkt_pend), .rx_err(rx_err));

  int checks = 0, bad = 0;
  bit [7:0] mem [int];
  int m_cnt = 0, m_timer = 0, m_lo = 0, m_hi = 'h17FF, m_rdp = 'h17FF, m_wp = 0;
  int wr_cycles = 0;
  bit m_err = 0, m_seterr = 0, m_en = 0, in_rst = 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (!in_rst) begin
    int dec, inc;
    dec = (pkt_dec && m_cnt > 0) ? 1 : 0;
    inc = 0;
    if (m_timer > 0) begin
      m_timer--;
      if (m_timer == 0) inc = 1;
    end
    m_cnt = m_cnt + inc - dec;
    if (m_seterr) begin m_err = 1; m_seterr = 0; end
    else if (err_clr) m_err = 0;
  end

  always @(negedge clk) if (!in_rst) begin
    if (mem_we) begin
      mem[int'(mem_addr)] = mem_wdata;
      wr_cycles++;
      chk(int'(mem_addr) >= m_lo && int'(mem_addr) <= m_hi, "R6 write inside ring", int'(mem_addr), m_lo);
      chk(int'(mem_addr) != m_rdp, "R7 no write at read pointer", int'(mem_addr), m_rdp);
    end
    chk(int'(pkt_cnt) == m_cnt, "R5 counter", int'(pkt_cnt), m_cnt);
    chk(pkt_pend == (m_cnt != 0), "R5 pending flag", int'(pkt_pend), int'(m_cnt != 0));
    chk(rx_err == m_err, "R12 error flag", int'(rx_err), int'(m_err));
  end

  function automatic int wrapa(int b, int o);
    int s = b + o;
    if (s > m_hi) s = s - (m_hi - m_lo + 1);
    return s;
  endfunction

  task automatic cfg(input int sel, input int val);
    @(negedge clk); cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = AW'(val);
    @(negedge clk); cfg_we = 0;
    if (sel == 0) begin m_lo = val; m_wp = val; end
    else if (sel == 1) m_hi = val;
    else m_rdp = val;
  endtask

  task automatic pulse_dec();
    @(negedge clk); pkt_dec = 1; @(negedge clk); pkt_dec = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
  endtask

  task automatic arm();
    @(negedge clk); rx_arm = 1; @(negedge clk); rx_arm = 0; m_en = 1;
  endtask

  task automatic send(input int n, input bit good, input int seed, input string req, input bit exp_acc);
    int hdr, free, need, w0, nxt, miss;
    bit acc;
    hdr = m_wp; w0 = wr_cycles;
    free = (m_rdp >= hdr) ? m_rdp - hdr : m_rdp + (m_hi - m_lo + 1) - hdr;
    need = 6 + n + (n % 2);
    acc = m_en && n <= MAXL && need <= free && m_cnt < CMAX;
    chk(acc == exp_acc, {req, " bench plan"}, int'(acc), int'(exp_acc));
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = 8'(seed + i); rx_last = (i == n - 1); rx_good = good;
      if (i == n - 1) begin
        if (acc) m_timer = 7;
        else if (m_en) m_seterr = 1;
      end
    end
    @(negedge clk); rx_valid = 0; rx_last = 0;
    repeat (8) @(negedge clk);
    if (!m_en) chk(wr_cycles == w0, {req, " ignored frame writes nothing"}, wr_cycles - w0, 0);
    if (acc) begin
      nxt = wrapa(hdr, need);
      chk({mem[wrapa(hdr,1)], mem[wrapa(hdr,0)]} == 16'(nxt), {req, " header next"},
          int'({mem[wrapa(hdr,1)], mem[wrapa(hdr,0)]}), nxt);
      chk({mem[wrapa(hdr,3)], mem[wrapa(hdr,2)]} == 16'(n), "R2 header length",
          int'({mem[wrapa(hdr,3)], mem[wrapa(hdr,2)]}), n);
      chk({mem[wrapa(hdr,5)], mem[wrapa(hdr,4)]} == (good ? 16'h0080 : 16'h0000), "R3 status word",
          int'({mem[wrapa(hdr,5)], mem[wrapa(hdr,4)]}), good ? 'h80 : 0);
      miss = 0;
      for (int i = 0; i < n; i++) if (mem[wrapa(hdr, 6 + i)] != 8'(seed + i)) miss++;
      chk(miss == 0, "R2 payload bytes", miss, 0);
      m_wp = nxt;
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; in_rst = 0;
    @(negedge clk);
    chk(pkt_cnt == 0 && !pkt_pend && !rx_err && !mem_we, "R1 reset state",
        int'({pkt_cnt, pkt_pend, rx_err, mem_we}), 0);
    send(5, 1, 'h10, "R11 disarmed", 0);
    arm();
    send(10, 1, 'h20, "R1 R4 default ring", 1);
    chk(m_wp == 'h10, "R4 next pointer", m_wp, 'h10);
    send(7, 0, 'h40, "R4 odd length rounded even", 1);
    chk(m_wp == 'h1E, "R4 even next pointer", m_wp, 'h1E);
    pulse_dec(); pulse_dec(); pulse_dec();
    chk(pkt_cnt == 0, "R5 decrement ignored at zero", int'(pkt_cnt), 0);
    cfg(0, 'h100); cfg(1, 'h17F); cfg(2, 'h17F);
    send(30, 1, 'h50, "R13 start reload", 1);
    send(30, 1, 'h60, "R4 chain", 1);
    send(30, 1, 'h70, "R4 chain", 1);
    send(30, 1, 'h80, "R7 overtake", 0);
    chk(rx_err == 1, "R7 error on overtake", int'(rx_err), 1);
    send(1, 1, 'h90, "R7 position kept", 1);
    chk(m_wp == 'h174, "R7 write position unchanged", m_wp, 'h174);
    pulse_clr();
    chk(rx_err == 0, "R12 error cleared", int'(rx_err), 0);
    cfg(2, 'h173);
    send(30, 1, 'hA0, "R6 wrap", 1);
    chk(m_wp == 'h118, "R6 wrapped next", m_wp, 'h118);
    cfg(2, 'h117);
    send(2, 1, 'hB0, "R8 fill", 1);
    send(2, 1, 'hB8, "R8 fill", 1);
    chk(pkt_cnt == CMAX, "R8 counter full", int'(pkt_cnt), CMAX);
    send(2, 1, 'hC0, "R8 saturated", 0);
    chk(pkt_cnt == CMAX && rx_err, "R8 saturation drop", int'({rx_err, pkt_cnt}), 'h8 | CMAX);
    for (int i = 0; i < CMAX; i++) pulse_dec();
    pulse_clr();
    cfg(2, 'h127);
    send(MAXL, 1, 'hD0, "R9 max length", 1);
    cfg(2, 'h16D);
    send(MAXL + 1, 1, 'hE0, "R9 too long", 0);
    chk(rx_err == 1, "R9 error on long frame", int'(rx_err), 1);
    @(negedge clk); ring_hold = 1; m_en = 0;
    send(4, 1, 'hF0, "R10 during hold", 0);
    @(negedge clk); ring_hold = 0;
    send(4, 1, 'hF4, "R10 after hold", 0);
    arm();
    send(4, 1, 'hF8, "R10 rearmed", 1);
    chk(m_wp == 'h178, "R10 rearmed position", m_wp, 'h178);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule